// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading descriptors from an in-memory translation table of one or two levels. A request is accepted through a valid/ready handshake. The walker then issues word reads on a memory read port that allows only one read in flight at a time. The answer is either a physical address or a fault flag together with the level at which the walk failed. A table base input and an enable input are captured when a request is accepted. With translation off, the address comes back unchanged and memory is never read.

A first-level descriptor either maps a 1MB region directly or points at a 1KB-aligned second-level table of 256 entries, each covering a 4KB page. The walk is therefore one read long for a region mapping or a first-level fault, and two dependent reads long when the table has to be followed. The second read address is built from the upper bits of the first descriptor and the middle bits of the virtual address. The result is held until the consumer takes it, and no new request is accepted while a walk or an unaccepted result is pending.

Top module: `xlat_walker`

## Requirements
- R1: While reset is active and after it is released, req_ready is 1, mem_rd_valid is 0 and rsp_valid is 0, including when reset arrives in the middle of a walk.
- R2: A request accepted with xlat_en low returns rsp_pa equal to req_va, rsp_fault 0 and rsp_fault_lvl 0, issues no memory read, and raises rsp_valid one clock edge after the accepting edge.
- R3: The first read of a walk goes to {tbl_base[31:14], req_va[31:20], 2'b00}; low bits of tbl_base are ignored. A new read is never requested while a read is still awaiting its data.
- R4: A first-level descriptor with bits [1:0] = 2'b10 ends the walk after one read with rsp_pa = {desc[31:20], va[19:0]} and rsp_fault 0. rsp_valid rises three edges after the accepting edge when memory does not stall.
- R5: A first-level descriptor with bits [1:0] = 2'b00 or 2'b11 ends the walk after one read with rsp_fault 1 and rsp_fault_lvl 1, three edges after acceptance when memory does not stall. rsp_fault_lvl is 0 whenever rsp_fault is 0.
- R6: A first-level descriptor with bits [1:0] = 2'b01 causes exactly one more read, to {desc[31:10], va[19:12], 2'b00}, so bits [9:0] of the descriptor are ignored.
- R7: A second-level descriptor with bit 1 set (bits [1:0] = 2'b10 or 2'b11) gives rsp_pa = {desc[31:12], va[11:0]} and rsp_fault 0. rsp_valid rises five edges after acceptance when memory does not stall.
- R8: A second-level descriptor with bits [1:0] = 2'b00 or 2'b01 gives rsp_fault 1 and rsp_fault_lvl 2 after two reads.
- R9: rsp_valid, rsp_pa, rsp_fault and rsp_fault_lvl stay constant while rsp_ready is low. req_ready is 0 from the accepting edge until the edge at which the result is taken.
- R10: When mem_rd_valid is high and mem_rd_ready low, mem_rd_valid stays high and mem_rd_addr stays constant on the next cycle. Results are unaffected by read-port stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_en | input | 1 | Translation enable, sampled on request acceptance |
| tbl_base | input | 32 | First-level table base, sampled on request acceptance |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address (meaningless when rsp_fault is 1) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 2 | Fault level: 1 or 2, 0 when no fault |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Word address of the descriptor |
| mem_rd_data_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Descriptor word |

## Verification
The bench's memory model returns data one cycle after it accepts a read. With the read port never stalling, a result is therefore due 1, 3 or 5 edges after the accepting edge, for zero, one or two reads. Each lookup counts edges from acceptance and checks rsp_valid at the negedge of exactly that cycle, along with the number and addresses of the reads it logged. In the stalled runs the latency check is switched off, and only the values, the read count and the read addresses are compared. Hold behaviour is checked on every cycle that rsp_ready is kept low.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_DONE
   } walk_st_t;

   // classification of a fetched descriptor
   typedef enum logic [1:0] {
      DK_FAULT = 2'd0,
      DK_NEXT  = 2'd1,
      DK_LEAF  = 2'd2
   } dkind_t;

endpackage

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
   import xlat_pkg::*;
#(
   parameter bit SECOND_LEVEL = 1'b0
) (
   input  logic [1:0] type_bits,
   output dkind_t     kind
);

   if (SECOND_LEVEL) begin : g_lvl2
      // bit 1 set: small page; otherwise fault (incl. large page)
      always_comb kind = type_bits[1] ? DK_LEAF : DK_FAULT;
   end else begin : g_lvl1
      always_comb begin
         case (type_bits)
            2'b01:   kind = DK_NEXT;
            2'b10:   kind = DK_LEAF;
            default: kind = DK_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/xlat_addr_build.sv
module xlat_addr_build #(
   parameter int ADDR_W   = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int OFF_W    = 12,
   localparam int L1_SPAN     = L2_IDX_W + OFF_W,
   localparam int L1_BASE_LSB = L1_IDX_W + 2,
   localparam int L2_BASE_LSB = L2_IDX_W + 2
) (
   input  logic [ADDR_W-1:0]             va,
   input  logic [ADDR_W-L1_BASE_LSB-1:0] base_hi,
   input  logic [ADDR_W-L2_BASE_LSB-1:0] tbl_hi,
   input  logic [L1_IDX_W-1:0]           sect_hi,
   input  logic [ADDR_W-OFF_W-1:0]       page_hi,
   output logic [ADDR_W-1:0]             l1_addr,
   output logic [ADDR_W-1:0]             l2_addr,
   output logic [ADDR_W-1:0]             sect_pa,
   output logic [ADDR_W-1:0]             page_pa
);

   assign l1_addr = {base_hi, va[ADDR_W-1 -: L1_IDX_W], 2'b00};
   assign l2_addr = {tbl_hi, va[OFF_W +: L2_IDX_W], 2'b00};
   assign sect_pa = {sect_hi, va[L1_SPAN-1:0]};
   assign page_pa = {page_hi, va[OFF_W-1:0]};

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int OFF_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlat_en,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_fault,
   output logic [1:0]        rsp_fault_lvl,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_data_valid,
   input  logic [ADDR_W-1:0] mem_rd_data
);

   localparam int L1_BASE_LSB = L1_IDX_W + 2;
   localparam int L2_BASE_LSB = L2_IDX_W + 2;

   // elaboration-time parameter checks
   if (L1_IDX_W + L2_IDX_W + OFF_W != ADDR_W) begin : g_bad_split
      $error("xlat_walker: index and offset widths must add up to ADDR_W");
   end
   if (L2_BASE_LSB > OFF_W) begin : g_bad_l2
      $error("xlat_walker: second-level table larger than one page");
   end

   walk_st_t                        st;
   logic [ADDR_W-1:0]               va_q;
   logic [ADDR_W-L1_BASE_LSB-1:0]   base_q;
   logic [ADDR_W-L2_BASE_LSB-1:0]   tbl_q;
   logic [ADDR_W-1:0]               pa_q;
   logic                            flt_q;
   logic [1:0]                      lvl_q;

   dkind_t                          l1_kind, l2_kind;
   logic [ADDR_W-1:0]               l1_addr, l2_addr, sect_pa, page_pa;
   logic                            unused_bits;

   assign unused_bits = ^{mem_rd_data[L2_BASE_LSB-1:2], tbl_base[L1_BASE_LSB-1:0]};

   xlat_desc_decode #(.SECOND_LEVEL(1'b0)) u_dec_l1 (
      .type_bits (mem_rd_data[1:0]),
      .kind      (l1_kind)
   );

   xlat_desc_decode #(.SECOND_LEVEL(1'b1)) u_dec_l2 (
      .type_bits (mem_rd_data[1:0]),
      .kind      (l2_kind)
   );

   xlat_addr_build #(
      .ADDR_W   (ADDR_W),
      .L1_IDX_W (L1_IDX_W),
      .L2_IDX_W (L2_IDX_W),
      .OFF_W    (OFF_W)
   ) u_addr (
      .va      (va_q),
      .base_hi (base_q),
      .tbl_hi  (tbl_q),
      .sect_hi (mem_rd_data[ADDR_W-1 -: L1_IDX_W]),
      .page_hi (mem_rd_data[ADDR_W-1:OFF_W]),
      .l1_addr (l1_addr),
      .l2_addr (l2_addr),
      .sect_pa (sect_pa),
      .page_pa (page_pa)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         va_q   <= '0;
         base_q <= '0;
         tbl_q  <= '0;
         pa_q   <= '0;
         flt_q  <= 1'b0;
         lvl_q  <= 2'd0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  base_q <= tbl_base[ADDR_W-1:L1_BASE_LSB];
                  pa_q   <= req_va;
                  flt_q  <= 1'b0;
                  lvl_q  <= 2'd0;
                  st     <= xlat_en ? ST_L1_REQ : ST_DONE;
               end
            end
            ST_L1_REQ: begin
               if (mem_rd_ready) st <= ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
               if (mem_rd_data_valid) begin
                  case (l1_kind)
                     DK_LEAF: begin
                        pa_q <= sect_pa;
                        st   <= ST_DONE;
                     end
                     DK_NEXT: begin
                        tbl_q <= mem_rd_data[ADDR_W-1:L2_BASE_LSB];
                        st    <= ST_L2_REQ;
                     end
                     default: begin
                        flt_q <= 1'b1;
                        lvl_q <= 2'd1;
                        st    <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_L2_REQ: begin
               if (mem_rd_ready) st <= ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
               if (mem_rd_data_valid) begin
                  if (l2_kind == DK_LEAF) begin
                     pa_q <= page_pa;
                  end else begin
                     flt_q <= 1'b1;
                     lvl_q <= 2'd2;
                  end
                  st <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (rsp_ready) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == ST_IDLE);
   assign mem_rd_valid  = (st == ST_L1_REQ) || (st == ST_L2_REQ);
   assign mem_rd_addr   = (st == ST_L2_REQ) ? l2_addr : l1_addr;
   assign rsp_valid     = (st == ST_DONE);
   assign rsp_pa        = pa_q;
   assign rsp_fault     = flt_q;
   assign rsp_fault_lvl = lvl_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int ADDR_W   = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int OFF_W    = 12,
   localparam int L1_BASE_LSB = L1_IDX_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xlat_en,
   input logic [ADDR_W-1:0] tbl_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_va,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_pa,
   input logic              rsp_fault,
   input logic [1:0]        rsp_fault_lvl,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_data_valid,
   input logic [ADDR_W-1:0] mem_rd_data
);

   logic                          outst;
   logic [1:0]                    nrd;
   logic                          en_c;
   logic [ADDR_W-L1_BASE_LSB-1:0] base_c;
   logic [L1_IDX_W-1:0]           vidx_c;
   logic                          unused_chk;

   assign unused_chk = ^{mem_rd_data, tbl_base[L1_BASE_LSB-1:0],
                         req_va[ADDR_W-L1_IDX_W-1:0], L2_IDX_W[0], OFF_W[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst  <= 1'b0;
         nrd    <= 2'd0;
         en_c   <= 1'b0;
         base_c <= '0;
         vidx_c <= '0;
      end else begin
         if (mem_rd_valid && mem_rd_ready) outst <= 1'b1;
         else if (mem_rd_data_valid)       outst <= 1'b0;
         if (req_valid && req_ready) begin
            nrd    <= 2'd0;
            en_c   <= xlat_en;
            base_c <= tbl_base[ADDR_W-1:L1_BASE_LSB];
            vidx_c <= req_va[ADDR_W-1 -: L1_IDX_W];
         end else if (mem_rd_valid && mem_rd_ready && nrd != 2'd3) begin
            nrd <= nrd + 2'd1;
         end
      end
   end

   assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_rd_valid);

   assert_l1_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && nrd == 2'd0) |-> (mem_rd_addr == {base_c, vidx_c, 2'b00}));

   assert_no_read_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_c && !req_ready) |-> !mem_rd_valid);

   assert_at_most_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nrd != 2'd3);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_rd_valid));

   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
                                     $stable(rsp_fault) && $stable(rsp_fault_lvl)));

   assert_busy_while_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   assert_fault_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault ? (rsp_fault_lvl == 2'd1 || rsp_fault_lvl == 2'd2)
                               : (rsp_fault_lvl == 2'd0)));

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

endmodule

bind xlat_walker xlat_walker_chk #(
   .ADDR_W   (ADDR_W),
   .L1_IDX_W (L1_IDX_W),
   .L2_IDX_W (L2_IDX_W),
   .OFF_W    (OFF_W)
) u_chk (.*);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] va;
      logic        en;
      logic [31:0] pa;
      logic        flt;
      logic [1:0]  lvl;
      logic [1:0]  nrd;
   } vec_t;

   localparam int NV = 12;
   localparam logic [31:0] TB = 32'h0010_0000;

   localparam vec_t VECS [NV] = '{
      '{TB,            32'h0012_3456, 1'b1, 32'h8002_3456, 1'b0, 2'd0, 2'd1}, // R4 section
      '{TB,            32'h0020_5ABC, 1'b1, 32'h1234_5ABC, 1'b0, 2'd0, 2'd2}, // R7 page 10
      '{TB,            32'h0020_6010, 1'b1, 32'h5555_6010, 1'b0, 2'd0, 2'd2}, // R7 page 11
      '{TB,            32'h0020_7000, 1'b1, 32'h0,         1'b1, 2'd2, 2'd2}, // R8 type 00
      '{TB,            32'h0020_8FFF, 1'b1, 32'h0,         1'b1, 2'd2, 2'd2}, // R8 type 01
      '{TB,            32'h0030_0000, 1'b1, 32'h0,         1'b1, 2'd1, 2'd1}, // R5 type 00
      '{TB,            32'h0040_0000, 1'b1, 32'h0,         1'b1, 2'd1, 2'd1}, // R5 type 11
      '{TB,            32'hFFFF_FFFF, 1'b1, 32'hABCF_FFFF, 1'b0, 2'd0, 2'd1}, // R4 top index
      '{TB,            32'h005F_F123, 1'b1, 32'h7777_7123, 1'b0, 2'd0, 2'd2}, // R6 masking
      '{TB,            32'h0012_3456, 1'b0, 32'h0012_3456, 1'b0, 2'd0, 2'd0}, // R2 bypass
      '{32'h0010_2ABC, 32'h0012_3456, 1'b1, 32'h8002_3456, 1'b0, 2'd0, 2'd1}, // R3 base low bits
      '{TB,            32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 1'b0, 2'd0, 2'd0}  // R2 bypass
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        xlat_en;
   logic [31:0] tbl_base;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_va;
   logic        rsp_valid;
   logic        rsp_ready;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic [1:0]  rsp_fault_lvl;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b1;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_data_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;

   always #4 clk = ~clk;

   xlat_walker uut (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
      .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data_valid(mem_rd_data_valid),
      .mem_rd_data(mem_rd_data)
   );

   // sparse descriptor memory
   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_log [64];
   int          rd_cnt = 0;
   bit          stall_mode = 1'b0;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      mem_rd_data_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
         mem_rd_data_valid       <= 1'b1;
         mem_rd_data             <= peek(mem_rd_addr);
         rd_log[rd_cnt % 64]     <= mem_rd_addr;
         rd_cnt                  <= rd_cnt + 1;
      end
      mem_rd_ready <= stall_mode ? ~mem_rd_ready : 1'b1;
   end

   int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // R10: a stalled read request stays put
   logic        prev_v = 1'b0, prev_r = 1'b0;
   logic [31:0] prev_a = '0;
   always @(negedge clk) begin
      if (rst_n === 1'b1 && prev_v && !prev_r) begin
         mon_chk++;
         if (!(mem_rd_valid && mem_rd_addr == prev_a)) begin
            mon_err++;
            $display("FAIL R10 stalled read dropped actual=%h expected=%h",
                     mem_rd_addr, prev_a);
         end
      end
      prev_v = (rst_n === 1'b1) && mem_rd_valid;
      prev_r = mem_rd_ready;
      prev_a = mem_rd_addr;
   end

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", n_chk + mon_chk, n_err + mon_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   task automatic lookup(input vec_t v, input bit chk_lat, input int hold);
      int          start;
      int          cyc;
      int          nreads;
      string       tag;
      logic [31:0] l1a, l1d, l2a, pa_seen;
      tag = (v.nrd == 0) ? "R2" : (v.flt && v.lvl == 1) ? "R5" :
            (v.flt) ? "R8" : (v.nrd == 1) ? "R4" : "R7";
      @(negedge clk);
      check(req_ready, "R9", "req_ready before request", {31'b0, req_ready}, 32'h1);
      start     = rd_cnt;
      tbl_base  = v.base;
      xlat_en   = v.en;
      req_va    = v.va;
      req_valid = 1'b1;
      rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      check(!req_ready, "R9", "req_ready after accept", {31'b0, req_ready}, 32'h0);
      while (!rsp_valid && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      if (chk_lat)
         check(cyc == 1 + 2 * int'(v.nrd), tag, "latency", cyc, 1 + 2 * int'(v.nrd));
      check(rsp_fault == v.flt, tag, "fault flag", {31'b0, rsp_fault}, {31'b0, v.flt});
      check(rsp_fault_lvl == v.lvl, tag, "fault level", {30'b0, rsp_fault_lvl}, {30'b0, v.lvl});
      if (!v.flt) check(rsp_pa == v.pa, tag, "physical address", rsp_pa, v.pa);
      nreads = rd_cnt - start;
      check(nreads == int'(v.nrd), tag, "read count", nreads, {30'b0, v.nrd});
      l1a = {v.base[31:14], v.va[31:20], 2'b00};
      if (v.nrd >= 1)
         check(rd_log[start % 64] == l1a, "R3", "first read address", rd_log[start % 64], l1a);
      if (v.nrd == 2) begin
         l1d = peek(l1a);
         l2a = {l1d[31:10], v.va[19:12], 2'b00};
         check(rd_log[(start + 1) % 64] == l2a, "R6", "second read address",
               rd_log[(start + 1) % 64], l2a);
      end
      pa_seen = rsp_pa;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check(rsp_valid && rsp_pa == pa_seen && !req_ready, "R9", "result held",
               rsp_pa, pa_seen);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(!rsp_valid && req_ready, "R9", "result released", {31'b0, rsp_valid}, 32'h0);
   endtask

   initial begin
      mem[32'h0010_0004] = 32'h800F_FC12;
      mem[32'h0010_0008] = 32'h0020_0401;
      mem[32'h0020_0414] = 32'h1234_5002;
      mem[32'h0020_0418] = 32'h5555_6003;
      mem[32'h0020_0420] = 32'h9999_9001;
      mem[32'h0010_0010] = 32'h4000_0003;
      mem[32'h0010_3FFC] = 32'hABC0_0002;
      mem[32'h0010_0014] = 32'h0030_07FD;
      mem[32'h0030_07FC] = 32'h7777_7FFE;

      rst_n = 1'b0; xlat_en = 1'b0; tbl_base = '0;
      req_valid = 1'b0; req_va = '0; rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_valid && !mem_rd_valid, "R1", "state in reset",
            {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_rd_valid, "R1", "state after reset",
            {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);

      for (int i = 0; i < NV; i++) lookup(VECS[i], 1'b1, 0);

      // R9: consumer holds off for several cycles
      lookup(VECS[1], 1'b1, 4);
      lookup(VECS[5], 1'b1, 3);

      // R10: read port stalls every other cycle
      stall_mode = 1'b1;
      lookup(VECS[1], 1'b0, 0);
      lookup(VECS[8], 1'b0, 0);
      lookup(VECS[4], 1'b0, 0);
      lookup(VECS[7], 1'b0, 0);
      stall_mode = 1'b0;
      repeat (2) @(negedge clk);

      // R1: reset in the middle of a walk
      tbl_base = TB; xlat_en = 1'b1; req_va = VECS[1].va; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(req_ready && !rsp_valid && !mem_rd_valid, "R1", "reset mid-walk",
            {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_rd_valid, "R1", "idle after mid-walk reset",
            {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
      lookup(VECS[0], 1'b1, 0);

      report();
   end

endmodule